// File: doc/BRIEF.md
# Audio Codec Mixer Register File

This block is the control-register store of an audio codec mixer. A host reaches it through a plain word port. Each cycle the port presents a 7-bit byte address, and optionally a write strobe with 16-bit data. Read data is a combinational function of the address and the stored state, so it is valid in the same cycle as the address. A write takes effect at the next rising clock edge.

The block stores the volume words, the capture-source word, the power-down word, the extended capability and extended control words, three sample-rate words and two identification words. A few addresses follow special write rules. Writing the soft-reset address restores every register to its default. The power-down word protects its low status nibble. Each sample-rate word accepts writes only while its enable bit in the extended control word is set. The identification words never change. The three rate words also drive dedicated output pins, so the downstream converter clocking logic can follow them directly.

Top module: `cmix_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every register loads its default. The defaults are: master volume 0x8000, PCM-out volume 0x8808, capture select 0x0000, capture gain 0x8000, power-down 0x000F, extended capability 0x0009, extended control 0x0000, each rate word 0xBB80, identification words 0x5A4B (0x7C) and 0x3041 (0x7E).
- R2: A write to address 0x00, with any data, restores every register to the R1 defaults at the next edge.
- R3: A write to the power-down word (0x26) stores the written bits 14:4 and clears bit 15. Bits 3:0 keep their previous value.
- R4: A write to the front DAC rate word (0x2C) or the LR ADC rate word (0x32) is stored only while bit 0 of the extended control word (0x2A) is 1. Otherwise the word is unchanged.
- R5: A write to the mic ADC rate word (0x34) is stored only while bit 3 of the extended control word is 1. Otherwise the word is unchanged.
- R6: A write to master volume (0x02), PCM-out volume (0x18), capture select (0x1A), capture gain (0x1C), extended capability (0x28) or extended control (0x2A) stores all 16 data bits.
- R7: Writes to the identification words (0x7C, 0x7E) are ignored, and they keep their default values.
- R8: A read of any address outside the map returns 0x0000, and so does a read of address 0x00. An odd address reads and writes the even address below it.
- R9: The outputs `dac_rate`, `adc_rate` and `mic_rate` always equal the stored words at 0x2C, 0x32 and 0x34.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 7 | Byte address; bit 0 is ignored |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data for `addr` |
| dac_rate | output | 16 | Stored front DAC rate |
| adc_rate | output | 16 | Stored LR ADC rate |
| mic_rate | output | 16 | Stored mic ADC rate |

## Verification
The bench drives several kinds of writes: random data to the plain words, writes to the rate words with the enable bits in the extended control word both set and clear, power-down writes with every bit pattern, and writes to the read-only identification words. These patterns separate a correctly gated rate word from one that always or never accepts writes. They also separate a status nibble that is held from one that is overwritten. Further stimulus covers random addresses, including odd and unmapped ones, and occasional soft-reset writes placed among other traffic. These show whether address aliasing is correct, whether unmapped reads return zero, and whether a soft reset restores every word and not only some of them.

// File: rtl/cmix_pkg.sv
package cmix_pkg;

    parameter int unsigned DW = 16;
    parameter int unsigned AW = 7;

    typedef enum logic [3:0] {
        SL_MASTER = 4'd0,
        SL_PCMOUT = 4'd1,
        SL_CAPSEL = 4'd2,
        SL_CAPGN  = 4'd3,
        SL_PWR    = 4'd4,
        SL_XCAP   = 4'd5,
        SL_XCTL   = 4'd6,
        SL_DAC    = 4'd7,
        SL_ADC    = 4'd8,
        SL_MIC    = 4'd9,
        SL_ID0    = 4'd10,
        SL_ID1    = 4'd11,
        SL_SRST   = 4'd12,
        SL_NONE   = 4'd13
    } slot_e;

    localparam int unsigned NSLOT = 12;
    localparam int unsigned IW    = $clog2(NSLOT);

    // extended control enable bits
    localparam int unsigned XCTL_RATE_EN = 0;
    localparam int unsigned XCTL_MIC_EN  = 3;

    // power-down word: bits dropped from write data, bits held from storage
    localparam logic [DW-1:0] PWR_DROP = 16'h800F;
    localparam logic [DW-1:0] PWR_HOLD = 16'h000F;

    localparam logic [DW-1:0] RATE_DEFAULT = 16'hBB80;

    typedef struct packed {
        logic            en;
        logic [IW-1:0]   idx;
        logic [DW-1:0]   val;
    } wr_op_t;

    function automatic slot_e decode_addr(input logic [AW-1:0] even_addr);
        slot_e s;
        case (even_addr)
            7'h00:   s = SL_SRST;
            7'h02:   s = SL_MASTER;
            7'h18:   s = SL_PCMOUT;
            7'h1A:   s = SL_CAPSEL;
            7'h1C:   s = SL_CAPGN;
            7'h26:   s = SL_PWR;
            7'h28:   s = SL_XCAP;
            7'h2A:   s = SL_XCTL;
            7'h2C:   s = SL_DAC;
            7'h32:   s = SL_ADC;
            7'h34:   s = SL_MIC;
            7'h7C:   s = SL_ID0;
            7'h7E:   s = SL_ID1;
            default: s = SL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DW-1:0] reset_value(input int unsigned idx);
        logic [DW-1:0] v;
        case (idx)
            0:       v = 16'h8000;
            1:       v = 16'h8808;
            2:       v = 16'h0000;
            3:       v = 16'h8000;
            4:       v = 16'h000F;
            5:       v = 16'h0009;
            6:       v = 16'h0000;
            7, 8, 9: v = RATE_DEFAULT;
            10:      v = 16'h5A4B;
            11:      v = 16'h3041;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cmix_decode.sv
module cmix_decode
    import cmix_pkg::*;
(
    input  logic [AW-1:0] addr,
    output slot_e         slot
);
    logic [AW-1:0] even_addr;

    always_comb begin
        even_addr = addr & ~{{(AW-1){1'b0}}, 1'b1};
        slot      = decode_addr(even_addr);
    end
endmodule

// File: rtl/cmix_wpolicy.sv
module cmix_wpolicy
    import cmix_pkg::*;
(
    input  logic          wr_en,
    input  slot_e         slot,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pwr_cur,
    input  logic [DW-1:0] xctl_cur,
    output logic          soft_rst,
    output wr_op_t        op
);
    always_comb begin
        soft_rst = wr_en && (slot == SL_SRST);
        op.en    = 1'b0;
        op.idx   = '0;
        op.val   = wdata;
        if (wr_en) begin
            case (slot)
                SL_MASTER, SL_PCMOUT, SL_CAPSEL, SL_CAPGN, SL_XCAP, SL_XCTL: begin
                    op.en  = 1'b1;
                    op.idx = IW'(slot);
                end
                SL_PWR: begin
                    op.en  = 1'b1;
                    op.idx = IW'(slot);
                    op.val = (wdata & ~PWR_DROP) | (pwr_cur & PWR_HOLD);
                end
                SL_DAC, SL_ADC: begin
                    op.en  = xctl_cur[XCTL_RATE_EN];
                    op.idx = IW'(slot);
                end
                SL_MIC: begin
                    op.en  = xctl_cur[XCTL_MIC_EN];
                    op.idx = IW'(slot);
                end
                default: op.en = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cmix_bank.sv
module cmix_bank
    import cmix_pkg::*;
#(
    parameter int unsigned N = NSLOT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 soft_rst,
    input  wr_op_t               op,
    output logic [N-1:0][DW-1:0] regs
);
    for (genvar i = 0; i < N; i++) begin : g_word
        localparam logic [DW-1:0] DEF = reset_value(i);
        always_ff @(posedge clk) begin
            if (rst || soft_rst) begin
                regs[i] <= DEF;
            end else if (op.en && (op.idx == IW'(i))) begin
                regs[i] <= op.val;
            end
        end

        AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
            soft_rst |=> regs[i] == DEF) else $error("soft reset default"); // R2
    end
endmodule

// File: rtl/cmix_regfile.sv
module cmix_regfile
    import cmix_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [6:0]    addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    output logic [15:0]   dac_rate,
    output logic [15:0]   adc_rate,
    output logic [15:0]   mic_rate
);
    slot_e                     slot;
    logic                      soft_rst;
    wr_op_t                    op;
    logic [NSLOT-1:0][DW-1:0]  regs;

    cmix_decode u_dec (
        .addr (addr),
        .slot (slot)
    );

    cmix_wpolicy u_pol (
        .wr_en    (wr_en),
        .slot     (slot),
        .wdata    (wdata),
        .pwr_cur  (regs[SL_PWR]),
        .xctl_cur (regs[SL_XCTL]),
        .soft_rst (soft_rst),
        .op       (op)
    );

    cmix_bank #(.N(NSLOT)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .op       (op),
        .regs     (regs)
    );

    always_comb begin
        if (int'(slot) < NSLOT) rdata = regs[IW'(slot)];
        else                    rdata = '0;
    end

    assign dac_rate = regs[SL_DAC];
    assign adc_rate = regs[SL_ADC];
    assign mic_rate = regs[SL_MIC];

    AST_PWR_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && slot == SL_PWR) |=> (regs[SL_PWR][3:0] == $past(regs[SL_PWR][3:0])) && !regs[SL_PWR][15])
        else $error("power status nibble changed"); // R3
    AST_DAC_GATED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && slot == SL_DAC && !regs[SL_XCTL][XCTL_RATE_EN]) |=> $stable(dac_rate))
        else $error("dac rate written while disabled"); // R4
    AST_ADC_GATED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && slot == SL_ADC && !regs[SL_XCTL][XCTL_RATE_EN]) |=> $stable(adc_rate))
        else $error("adc rate written while disabled"); // R4
    AST_MIC_GATED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && slot == SL_MIC && !regs[SL_XCTL][XCTL_MIC_EN]) |=> $stable(mic_rate))
        else $error("mic rate written while disabled"); // R5
    AST_ID_CONST: assert property (@(posedge clk) disable iff (rst)
        $stable(regs[SL_ID0]) && $stable(regs[SL_ID1]))
        else $error("identification word changed"); // R7
endmodule

// File: tb/cmix_regfile_tb_top.sv
`timescale 1ns/1ps
module cmix_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [6:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata, dac_rate, adc_rate, mic_rate;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] mdl [12];

    always #2.5 clk = ~clk;

    cmix_regfile dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .dac_rate(dac_rate), .adc_rate(adc_rate), .mic_rate(mic_rate)
    );

    function automatic int idx_of(input logic [6:0] a);
        case ({a[6:1], 1'b0})
            7'h00: return -2;
            7'h02: return 0;  7'h18: return 1;  7'h1A: return 2;  7'h1C: return 3;
            7'h26: return 4;  7'h28: return 5;  7'h2A: return 6;  7'h2C: return 7;
            7'h32: return 8;  7'h34: return 9;  7'h7C: return 10; 7'h7E: return 11;
            default: return -1;
        endcase
    endfunction

    function automatic logic [15:0] def_of(input int i);
        case (i)
            0: return 16'h8000; 1: return 16'h8808; 2: return 16'h0000; 3: return 16'h8000;
            4: return 16'h000F; 5: return 16'h0009; 6: return 16'h0000;
            7, 8, 9: return 16'hBB80;
            10: return 16'h5A4B; 11: return 16'h3041;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] exp_read(input logic [6:0] a);
        int i = idx_of(a);
        if (i < 0) return 16'h0000;
        return mdl[i];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 12; i++) mdl[i] = def_of(i);
    endtask

    task automatic model_write(input logic [6:0] a, input logic [15:0] d);
        int i = idx_of(a);
        case (i)
            -2: model_reset();
            0, 1, 2, 3, 5, 6: mdl[i] = d;
            4: mdl[4] = (d & 16'h7FF0) | (mdl[4] & 16'h000F);
            7, 8: if (mdl[6][0]) mdl[i] = d;
            9: if (mdl[6][3]) mdl[9] = d;
            default: ;
        endcase
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_check(input string req, input logic [6:0] a);
        @(negedge clk);
        addr = a;
        #1 check(req, rdata, exp_read(a));
    endtask

    task automatic rates_check(input string req);
        @(negedge clk);
        #1;
        check(req, dac_rate, mdl[7]);
        check(req, adc_rate, mdl[8]);
        check(req, mic_rate, mdl[9]);
    endtask

    function automatic logic [6:0] pick_addr();
        logic [6:0] lst [13] = '{7'h02, 7'h18, 7'h1A, 7'h1C, 7'h26, 7'h28, 7'h2A,
                                  7'h2C, 7'h32, 7'h34, 7'h7C, 7'h7E, 7'h00};
        int r = int'($urandom_range(0, 99));
        logic [6:0] a;
        if (r < 2)       a = 7'h00;
        else if (r < 80) a = lst[$urandom_range(0, 11)];
        else             a = 7'($urandom());
        if ($urandom_range(0, 7) == 0) a[0] = 1'b1;
        return a;
    endfunction

    logic [6:0] map_list [13] = '{7'h00, 7'h02, 7'h18, 7'h1A, 7'h1C, 7'h26, 7'h28,
                                  7'h2A, 7'h2C, 7'h32, 7'h34, 7'h7C, 7'h7E};

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 defaults after reset
        for (int k = 0; k < 13; k++) rd_check("R1", map_list[k]);
        rates_check("R9");

        // R4: rate writes blocked while enable clear
        wr(7'h2C, 16'h1F40); rd_check("R4", 7'h2C);
        wr(7'h32, 16'h2B11); rd_check("R4", 7'h32);
        // R5: mic blocked
        wr(7'h34, 16'h3E80); rd_check("R5", 7'h34);
        // enable rate only
        wr(7'h2A, 16'h0001); rd_check("R6", 7'h2A);
        wr(7'h2C, 16'h5622); rd_check("R4", 7'h2C);
        wr(7'h32, 16'h7D00); rd_check("R4", 7'h32);
        wr(7'h34, 16'h1234); rd_check("R5", 7'h34);
        wr(7'h2A, 16'h0008);
        wr(7'h34, 16'hAC44); rd_check("R5", 7'h34);
        wr(7'h2C, 16'h0101); rd_check("R4", 7'h2C);
        rates_check("R9");

        // R3 power-down
        wr(7'h26, 16'hFFF0); rd_check("R3", 7'h26);
        wr(7'h26, 16'h0000); rd_check("R3", 7'h26);

        // R7 identification
        wr(7'h7C, 16'h0000); rd_check("R7", 7'h7C);
        wr(7'h7F, 16'hFFFF); rd_check("R7", 7'h7E);

        // R8 odd alias and unmapped
        wr(7'h03, 16'h1357); rd_check("R8", 7'h02); rd_check("R8", 7'h03);
        wr(7'h40, 16'hBEEF); rd_check("R8", 7'h40); rd_check("R8", 7'h00);
        rd_check("R6", 7'h02);

        // R2 soft reset with arbitrary data
        wr(7'h1A, 16'h0404);
        wr(7'h01, 16'h5555);
        for (int k = 0; k < 13; k++) rd_check("R2", map_list[k]);
        rates_check("R9");

        // random traffic: R6 plain stores and all rules
        for (int n = 0; n < 3000; n++) begin
            wr(pick_addr(), 16'($urandom()));
            rd_check("R6", pick_addr());
            if ((n % 16) == 0) rates_check("R9");
        end

        // R1 synchronous reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        model_reset();
        for (int k = 0; k < 13; k++) rd_check("R1", map_list[k]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule